// File: doc/BRIEF.md
# Address-Keyed Reorder Buffer

This block is the in-order retirement queue for a processor whose instructions read and write memory operands directly, with no architectural register file. Each decoded instruction receives a slot at the tail, and the slot records the full memory address its result will land at, plus a byte-size code. Operands are renamed by address: a lookup port searches every live slot for the most recently allocated one with the same destination address. It returns the slot tag while the result is still outstanding, the value once it exists, or a miss that sends the operand to the data cache.

Execution units return results by tag. A returned result is broadcast so that waiting instructions can capture it. A mispredicted branch poisons every slot allocated after it. Poisoned slots stay in the queue and are dropped silently when they reach the head. Commit examines the two oldest slots each cycle. It retires them in order and presents a memory write for each one that holds a real result. The depth must be a power of two.

Top module: `mem_addr_rob`

## Requirements
- R1: Each accepted allocation takes the slot at the tail. `allocTag` shows that slot's tag before the edge, and tags rise by one per allocation, wrapping modulo DEPTH.
- R2: With DEPTH slots occupied, `full` is 1 and `allocReady` is 0. An allocation request in that state changes nothing. Once a slot retires, allocation resumes at the next tag.
- R3: A lookup whose address equals no live slot's destination (all ADDR_W bits compared) reports `lkHit`=0.
- R4: A lookup matching a slot whose result is outstanding reports `lkHit`=1, `lkReady`=0 and that slot's tag on `lkTag`.
- R5: A lookup matching a slot that holds its result reports `lkHit`=1, `lkReady`=1, the slot tag and the stored value on `lkData`.
- R6: When several live slots share the address, the lookup reports the most recently allocated of them.
- R7: A lookup that matches the slot being written by `wbValid`/`wbTag` in the same cycle reports `lkReady`=1 with `wbData`.
- R8: A result write to a live slot drives `bcValid`=1 with `bcTag`=`wbTag` and `bcData`=`wbData` in the same cycle. A write to a poisoned slot drives `bcValid`=0.
- R9: Commit retires from the head in allocation order, at most two slots per cycle, and stops at the first slot with an outstanding result. Port 0 of the write interface carries the older slot and port 1 the next one. The writes appear in the cycle after the head slots become complete.
- R10: Each commit write presents the slot's destination address, its result and its size code (0=1 byte, 1=2, 2=4, 3=8 bytes).
- R11: A flush with `flushTag` poisons every live slot allocated after that tag, starting in the flush cycle itself. Poisoned slots are invisible to lookups and retire with their write enable held at 0.
- R12: In a flush cycle `allocReady` is 0 and no slot is allocated. The next allocation continues at the tag that followed the poisoned slots.
- R13: After reset the buffer is empty: `allocReady`=1, `full`=0, no write enable is set and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Decode requests a slot |
| allocAddr | input | ADDR_W | Destination memory address of the new instruction |
| allocSize | input | 2 | Destination size code |
| allocReady | output | 1 | A slot can be taken this cycle |
| allocTag | output | TAG_W | Tag the next slot will get |
| full | output | 1 | All slots occupied |
| lkAddr | input | NUM_LK x ADDR_W | Operand address per lookup port |
| lkHit | output | NUM_LK | Live slot found per port |
| lkReady | output | NUM_LK | Found slot has its result |
| lkTag | output | NUM_LK x TAG_W | Tag of the found slot |
| lkData | output | NUM_LK x DATA_W | Result of the found slot |
| wbValid | input | 1 | Result write strobe |
| wbTag | input | TAG_W | Slot being written |
| wbData | input | DATA_W | Result value |
| bcValid | output | 1 | Broadcast of a result to a live slot |
| bcTag | output | TAG_W | Broadcast tag |
| bcData | output | DATA_W | Broadcast value |
| flushValid | input | 1 | Branch mispredict |
| flushTag | input | TAG_W | Tag of the mispredicted branch |
| memWrEn | output | 2 | Commit write enable per port |
| memWrAddr | output | 2 x ADDR_W | Commit write address per port |
| memWrData | output | 2 x DATA_W | Commit write data per port |
| memWrSize | output | 2 x 2 | Commit write size code per port |

## Verification
The collision that matters is an operand search that lands on a slot in the very cycle its result is being written. The search must not return the tag it would have returned one cycle earlier. The bench drives a result write and a lookup of the same address in one cycle, before and after other slots with that address exist. It requires the ready flag and the incoming value rather than the outstanding tag. A second collision, a flush together with a search and an allocation request, is judged by whether the search already skips the poisoned slot and whether the tail stays put.

// File: rtl/mem_rob_pkg.sv
package mem_rob_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } memSize_e;

  // strobes the control sends the datapath each cycle
  typedef struct packed {
    logic allocEn;
    logic flushEn;
    logic retire0;
    logic retire1;
  } robStrobe_t;

endpackage

// File: rtl/mem_rob_ctrl.sv
module mem_rob_ctrl
  import mem_rob_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic             flushValid,
  input  logic             headReady0,
  input  logic             headReady1,
  output logic             allocReady,
  output logic             full,
  output robStrobe_t       strobe,
  output logic [TAG_W-1:0] headIdx,
  output logic [TAG_W-1:0] tailIdx,
  output logic [CNT_W-1:0] count
);

  logic [1:0]       nRetire;
  logic [CNT_W-1:0] countNext;

  assign full       = (count == CNT_W'(DEPTH));
  assign allocReady = !full && !flushValid;

  always_comb begin
    strobe         = '0;
    strobe.allocEn = allocValid && allocReady;
    strobe.flushEn = flushValid;
    strobe.retire0 = (count != '0) && headReady0;
    strobe.retire1 = strobe.retire0 && (count >= CNT_W'(2)) && headReady1;
    nRetire        = {1'b0, strobe.retire0} + {1'b0, strobe.retire1};
    countNext      = count + CNT_W'(strobe.allocEn) - CNT_W'(nRetire);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headIdx <= '0;
      tailIdx <= '0;
      count   <= '0;
    end else begin
      headIdx <= headIdx + TAG_W'(nRetire);
      tailIdx <= tailIdx + TAG_W'(strobe.allocEn);
      count   <= countNext;
    end
  end

  // occupancy never exceeds the slot count
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // a flush cycle never moves the tail
  assert_flush_tail_R12: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |=> (tailIdx == $past(tailIdx)));

endmodule

// File: rtl/mem_rob_dp.sv
module mem_rob_dp
  import mem_rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int NUM_LK = 2,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  robStrobe_t                     strobe,
  input  logic [TAG_W-1:0]               headIdx,
  input  logic [TAG_W-1:0]               tailIdx,
  input  logic [CNT_W-1:0]               count,
  input  logic [ADDR_W-1:0]              allocAddr,
  input  logic [1:0]                     allocSize,
  input  logic [TAG_W-1:0]               flushTag,
  input  logic                           wbValid,
  input  logic [TAG_W-1:0]               wbTag,
  input  logic [DATA_W-1:0]              wbData,
  input  logic [NUM_LK-1:0][ADDR_W-1:0]  lkAddr,
  output logic [NUM_LK-1:0]              lkHit,
  output logic [NUM_LK-1:0]              lkReady,
  output logic [NUM_LK-1:0][TAG_W-1:0]   lkTag,
  output logic [NUM_LK-1:0][DATA_W-1:0]  lkData,
  output logic                           headReady0,
  output logic                           headReady1,
  output logic                           bcValid,
  output logic [TAG_W-1:0]               bcTag,
  output logic [DATA_W-1:0]              bcData,
  output logic [1:0]                     memWrEn,
  output logic [1:0][ADDR_W-1:0]         memWrAddr,
  output logic [1:0][DATA_W-1:0]         memWrData,
  output logic [1:0][1:0]                memWrSize
);

  logic [ADDR_W-1:0] entAddr [DEPTH];
  logic [DATA_W-1:0] entData [DEPTH];
  memSize_e          entSize [DEPTH];
  logic [DEPTH-1:0]  entDone;
  logic [DEPTH-1:0]  entSquash;

  logic [DEPTH-1:0]  occMask;
  logic [DEPTH-1:0]  youngMask;
  logic [DEPTH-1:0]  effSquash;
  logic [DEPTH-1:0]  liveMask;
  logic [TAG_W-1:0]  flushAge;
  logic [TAG_W-1:0]  head1Idx;

  assign flushAge = flushTag - headIdx;
  assign head1Idx = headIdx + TAG_W'(1);

  // per-slot age relative to the head, occupancy and flush window
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [TAG_W-1:0] slotAge;
    assign slotAge      = TAG_W'(i) - headIdx;
    assign occMask[i]   = (CNT_W'(slotAge) < count);
    assign youngMask[i] = occMask[i] && (slotAge > flushAge);
  end

  // poisoning takes effect in the flush cycle itself
  assign effSquash = entSquash | (strobe.flushEn ? youngMask : '0);
  assign liveMask  = occMask & ~effSquash;

  assign headReady0 = entDone[headIdx]  | effSquash[headIdx];
  assign headReady1 = entDone[head1Idx] | effSquash[head1Idx];

  // commit write ports: port 0 is the older slot
  always_comb begin
    memWrEn[0]   = strobe.retire0 && !effSquash[headIdx];
    memWrAddr[0] = entAddr[headIdx];
    memWrData[0] = entData[headIdx];
    memWrSize[0] = entSize[headIdx];
    memWrEn[1]   = strobe.retire1 && !effSquash[head1Idx];
    memWrAddr[1] = entAddr[head1Idx];
    memWrData[1] = entData[head1Idx];
    memWrSize[1] = entSize[head1Idx];
  end

  // result broadcast
  assign bcValid = wbValid && liveMask[wbTag];
  assign bcTag   = wbTag;
  assign bcData  = wbData;

  // associative lookup, oldest to youngest so the last match wins
  for (genvar p = 0; p < NUM_LK; p++) begin : g_lk
    logic             found;
    logic [TAG_W-1:0] hitIdx;
    logic             bypass;

    always_comb begin
      found  = 1'b0;
      hitIdx = '0;
      for (int k = 0; k < DEPTH; k++) begin
        if (liveMask[headIdx + TAG_W'(k)] &&
            entAddr[headIdx + TAG_W'(k)] == lkAddr[p]) begin
          found  = 1'b1;
          hitIdx = headIdx + TAG_W'(k);
        end
      end
    end

    assign bypass     = found && wbValid && (wbTag == hitIdx);
    assign lkHit[p]   = found;
    assign lkTag[p]   = hitIdx;
    assign lkReady[p] = found && (bypass || entDone[hitIdx]);
    assign lkData[p]  = bypass ? wbData :
                        ((found && entDone[hitIdx]) ? entData[hitIdx] : '0);

    // a same-cycle write to the found slot is visible to the lookup
    assert_bypass_R7: assert property (@(posedge clk) disable iff (!rstN)
      (wbValid && lkHit[p] && lkTag[p] == wbTag) |->
        (lkReady[p] && lkData[p] == wbData));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entDone   <= '0;
      entSquash <= '0;
    end else begin
      if (strobe.flushEn) begin
        entSquash <= entSquash | youngMask;
      end
      if (wbValid) begin
        entDone[wbTag] <= 1'b1;
        entData[wbTag] <= wbData;
      end
      if (strobe.allocEn) begin
        entAddr[tailIdx]   <= allocAddr;
        entSize[tailIdx]   <= memSize_e'(allocSize);
        entDone[tailIdx]   <= 1'b0;
        entSquash[tailIdx] <= 1'b0;
      end
    end
  end

  // a broadcast slot holds its result afterwards
  assert_bcast_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    bcValid |=> entDone[$past(bcTag)]);

  // commit never writes a slot whose result is outstanding
  assert_commit_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn[0] |-> entDone[headIdx]);

  // poisoned head slots leave without a write
  assert_drop_silent_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.retire0 && entSquash[headIdx]) |-> !memWrEn[0]);

endmodule

// File: rtl/mem_addr_rob.sv
module mem_addr_rob
  import mem_rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int NUM_LK = 2,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           allocValid,
  input  logic [ADDR_W-1:0]              allocAddr,
  input  logic [1:0]                     allocSize,
  output logic                           allocReady,
  output logic [TAG_W-1:0]               allocTag,
  output logic                           full,
  input  logic [NUM_LK-1:0][ADDR_W-1:0]  lkAddr,
  output logic [NUM_LK-1:0]              lkHit,
  output logic [NUM_LK-1:0]              lkReady,
  output logic [NUM_LK-1:0][TAG_W-1:0]   lkTag,
  output logic [NUM_LK-1:0][DATA_W-1:0]  lkData,
  input  logic                           wbValid,
  input  logic [TAG_W-1:0]               wbTag,
  input  logic [DATA_W-1:0]              wbData,
  output logic                           bcValid,
  output logic [TAG_W-1:0]               bcTag,
  output logic [DATA_W-1:0]              bcData,
  input  logic                           flushValid,
  input  logic [TAG_W-1:0]               flushTag,
  output logic [1:0]                     memWrEn,
  output logic [1:0][ADDR_W-1:0]         memWrAddr,
  output logic [1:0][DATA_W-1:0]         memWrData,
  output logic [1:0][1:0]                memWrSize
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  robStrobe_t       strobe;
  logic [TAG_W-1:0] headIdx;
  logic [TAG_W-1:0] tailIdx;
  logic [CNT_W-1:0] count;
  logic             headReady0;
  logic             headReady1;

  assign allocTag = tailIdx;

  mem_rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .allocValid (allocValid),
    .flushValid (flushValid),
    .headReady0 (headReady0),
    .headReady1 (headReady1),
    .allocReady (allocReady),
    .full       (full),
    .strobe     (strobe),
    .headIdx    (headIdx),
    .tailIdx    (tailIdx),
    .count      (count)
  );

  mem_rob_dp #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_LK (NUM_LK)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .headIdx    (headIdx),
    .tailIdx    (tailIdx),
    .count      (count),
    .allocAddr  (allocAddr),
    .allocSize  (allocSize),
    .flushTag   (flushTag),
    .wbValid    (wbValid),
    .wbTag      (wbTag),
    .wbData     (wbData),
    .lkAddr     (lkAddr),
    .lkHit      (lkHit),
    .lkReady    (lkReady),
    .lkTag      (lkTag),
    .lkData     (lkData),
    .headReady0 (headReady0),
    .headReady1 (headReady1),
    .bcValid    (bcValid),
    .bcTag      (bcTag),
    .bcData     (bcData),
    .memWrEn    (memWrEn),
    .memWrAddr  (memWrAddr),
    .memWrData  (memWrData),
    .memWrSize  (memWrSize)
  );

endmodule

// File: tb/tb_mem_addr_rob.sv
module tb_mem_addr_rob;

  localparam int DEPTH  = 16;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int NUM_LK = 2;
  localparam int TAG_W  = 4;

  logic                          clk = 1'b0;
  logic                          rstN = 1'b0;
  logic                          allocValid = 1'b0;
  logic [ADDR_W-1:0]             allocAddr = '0;
  logic [1:0]                    allocSize = '0;
  logic                          allocReady;
  logic [TAG_W-1:0]              allocTag;
  logic                          full;
  logic [NUM_LK-1:0][ADDR_W-1:0] lkAddr = '0;
  logic [NUM_LK-1:0]             lkHit;
  logic [NUM_LK-1:0]             lkReady;
  logic [NUM_LK-1:0][TAG_W-1:0]  lkTag;
  logic [NUM_LK-1:0][DATA_W-1:0] lkData;
  logic                          wbValid = 1'b0;
  logic [TAG_W-1:0]              wbTag = '0;
  logic [DATA_W-1:0]             wbData = '0;
  logic                          bcValid;
  logic [TAG_W-1:0]              bcTag;
  logic [DATA_W-1:0]             bcData;
  logic                          flushValid = 1'b0;
  logic [TAG_W-1:0]              flushTag = '0;
  logic [1:0]                    memWrEn;
  logic [1:0][ADDR_W-1:0]        memWrAddr;
  logic [1:0][DATA_W-1:0]        memWrData;
  logic [1:0][1:0]               memWrSize;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mem_addr_rob #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LK(NUM_LK)) dut (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocAddr(allocAddr), .allocSize(allocSize),
    .allocReady(allocReady), .allocTag(allocTag), .full(full),
    .lkAddr(lkAddr), .lkHit(lkHit), .lkReady(lkReady), .lkTag(lkTag), .lkData(lkData),
    .wbValid(wbValid), .wbTag(wbTag), .wbData(wbData),
    .bcValid(bcValid), .bcTag(bcTag), .bcData(bcData),
    .flushValid(flushValid), .flushTag(flushTag),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData), .memWrSize(memWrSize)
  );

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              hit;
    logic              rdy;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
  } lkVec_t;

  // lookup table walked after the first fill (tags 0..3 live, 1 and 2 complete)
  localparam lkVec_t LK_TABLE [6] = '{
    '{addr: 32'h100, hit: 1'b1, rdy: 1'b1, tag: 4'd2, data: 64'hBB},  // R6 R5
    '{addr: 32'h200, hit: 1'b1, rdy: 1'b1, tag: 4'd1, data: 64'hAA},  // R5
    '{addr: 32'h300, hit: 1'b1, rdy: 1'b0, tag: 4'd3, data: 64'h0},   // R4
    '{addr: 32'h400, hit: 1'b0, rdy: 1'b0, tag: 4'd0, data: 64'h0},   // R3
    '{addr: 32'h101, hit: 1'b0, rdy: 1'b0, tag: 4'd0, data: 64'h0},   // R3
    '{addr: 32'h80000100, hit: 1'b0, rdy: 1'b0, tag: 4'd0, data: 64'h0} // R3
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    allocValid = 1'b0;
    wbValid    = 1'b0;
    flushValid = 1'b0;
  endtask

  task automatic nextCyc();
    @(negedge clk);
    quiet();
  endtask

  task automatic doAlloc(input logic [31:0] a, input logic [1:0] sz, input int expTag, input string req);
    allocValid = 1'b1;
    allocAddr  = a;
    allocSize  = sz;
    #1;
    chk(req, 64'(allocTag), 64'(expTag));
    nextCyc();
  endtask

  task automatic lookBoth(input logic [31:0] a);
    lkAddr[0] = a;
    lkAddr[1] = a;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    lookBoth(32'h100);
    #1;
    // R13 reset state
    chk("R13 allocReady", 64'(allocReady), 64'd1);
    chk("R13 full", 64'(full), 64'd0);
    chk("R13 memWrEn", 64'(memWrEn), 64'd0);
    chk("R13 lkHit", 64'(lkHit), 64'd0);
    nextCyc();

    // R1 fill: tags 0..3
    doAlloc(32'h100, 2'd3, 0, "R1 tag0");
    doAlloc(32'h200, 2'd0, 1, "R1 tag1");
    doAlloc(32'h100, 2'd2, 2, "R1 tag2");
    doAlloc(32'h300, 2'd1, 3, "R1 tag3");

    // R7 R8 write tag1 with a same-cycle lookup of its address
    lookBoth(32'h200);
    wbValid = 1'b1; wbTag = 4'd1; wbData = 64'hAA;
    #1;
    chk("R8 bcValid", 64'(bcValid), 64'd1);
    chk("R8 bcTag", 64'(bcTag), 64'd1);
    chk("R8 bcData", bcData, 64'hAA);
    chk("R7 lkReady", 64'(lkReady[0]), 64'd1);
    chk("R7 lkData", lkData[0], 64'hAA);
    chk("R9 no commit while head pending", 64'(memWrEn), 64'd0);
    nextCyc();
    // R7 youngest of two matches written in the same cycle
    lookBoth(32'h100);
    wbValid = 1'b1; wbTag = 4'd2; wbData = 64'hBB;
    #1;
    chk("R7 bypass youngest tag", 64'(lkTag[1]), 64'd2);
    chk("R7 bypass data", lkData[1], 64'hBB);
    nextCyc();

    // table walk on both ports: R3 R4 R5 R6
    foreach (LK_TABLE[i]) begin
      lookBoth(LK_TABLE[i].addr);
      #1;
      for (int p = 0; p < NUM_LK; p++) begin
        chk("R3/R4 hit", 64'(lkHit[p]), 64'(LK_TABLE[i].hit));
        if (LK_TABLE[i].hit) begin
          chk("R4/R5 ready", 64'(lkReady[p]), 64'(LK_TABLE[i].rdy));
          chk("R6 tag", 64'(lkTag[p]), 64'(LK_TABLE[i].tag));
          if (LK_TABLE[i].rdy) chk("R5 data", lkData[p], LK_TABLE[i].data);
        end
      end
      nextCyc();
    end

    // R9 complete head, two retire next cycle
    wbValid = 1'b1; wbTag = 4'd0; wbData = 64'h11;
    #1;
    chk("R9 none before head done", 64'(memWrEn), 64'd0);
    nextCyc();
    #1;
    chk("R9 two writes", 64'(memWrEn), 64'd3);
    chk("R10 addr0", 64'(memWrAddr[0]), 64'h100);
    chk("R10 data0", memWrData[0], 64'h11);
    chk("R10 size0", 64'(memWrSize[0]), 64'd3);
    chk("R10 addr1", 64'(memWrAddr[1]), 64'h200);
    chk("R10 data1", memWrData[1], 64'hAA);
    chk("R10 size1", 64'(memWrSize[1]), 64'd0);
    nextCyc();
    #1;
    chk("R9 stops at pending", 64'(memWrEn), 64'd1);
    chk("R10 addr tag2", 64'(memWrAddr[0]), 64'h100);
    chk("R10 data tag2", memWrData[0], 64'hBB);
    chk("R10 size tag2", 64'(memWrSize[0]), 64'd2);
    nextCyc();
    lookBoth(32'h100);
    #1;
    chk("R9 idle behind pending", 64'(memWrEn), 64'd0);
    chk("R3 retired address misses", 64'(lkHit[0]), 64'd0);
    nextCyc();

    // flush: tag3 pending, allocate 4 (branch), 5, 6
    doAlloc(32'h500, 2'd2, 4, "R1 tag4");
    doAlloc(32'h600, 2'd2, 5, "R1 tag5");
    doAlloc(32'h300, 2'd2, 6, "R1 tag6");
    lookBoth(32'h300);
    #1;
    chk("R6 before flush", 64'(lkTag[0]), 64'd6);
    flushValid = 1'b1; flushTag = 4'd4;
    allocValid = 1'b1; allocAddr = 32'h777;
    #1;
    chk("R12 allocReady in flush", 64'(allocReady), 64'd0);
    chk("R11 same-cycle lookup skips poisoned", 64'(lkTag[0]), 64'd3);
    nextCyc();
    lookBoth(32'h600);
    #1;
    chk("R11 poisoned slot invisible", 64'(lkHit[0]), 64'd0);
    chk("R12 tail held", 64'(allocTag), 64'd7);
    nextCyc();
    doAlloc(32'h700, 2'd1, 7, "R12 tag after flush");
    // cycle A: write a poisoned slot
    wbValid = 1'b1; wbTag = 4'd5; wbData = 64'h55;
    #1;
    chk("R8 no broadcast for poisoned", 64'(bcValid), 64'd0);
    nextCyc();
    // cycle B
    wbValid = 1'b1; wbTag = 4'd3; wbData = 64'h33;
    nextCyc();
    // cycle C
    #1;
    chk("R9 tag3 alone", 64'(memWrEn), 64'd1);
    chk("R10 tag3 addr", 64'(memWrAddr[0]), 64'h300);
    chk("R10 tag3 data", memWrData[0], 64'h33);
    wbValid = 1'b1; wbTag = 4'd4; wbData = 64'h44;
    nextCyc();
    // cycle D: tag4 writes, tag5 dropped
    #1;
    chk("R11 drop on port1", 64'(memWrEn), 64'd1);
    chk("R10 tag4 data", memWrData[0], 64'h44);
    nextCyc();
    // cycle E: tag6 dropped alone
    #1;
    chk("R11 silent drop", 64'(memWrEn), 64'd0);
    wbValid = 1'b1; wbTag = 4'd7; wbData = 64'h77;
    nextCyc();
    #1;
    chk("R9 tag7 write", 64'(memWrEn), 64'd1);
    chk("R10 tag7 addr", 64'(memWrAddr[0]), 64'h700);
    chk("R10 tag7 size", 64'(memWrSize[0]), 64'd1);
    nextCyc();
    #1;
    chk("R2 empty not full", 64'(full), 64'd0);

    // R2 fill all slots starting at tag 8
    for (int i = 0; i < DEPTH; i++) begin
      doAlloc(32'h1000 + 32'(i), 2'd2, (8 + i) % DEPTH, "R1 wrap tag");
    end
    #1;
    chk("R2 full", 64'(full), 64'd1);
    chk("R2 allocReady", 64'(allocReady), 64'd0);
    allocValid = 1'b1; allocAddr = 32'h9999;
    nextCyc();
    lookBoth(32'h9999);
    #1;
    chk("R2 refused alloc invisible", 64'(lkHit[0]), 64'd0);
    chk("R2 still full", 64'(full), 64'd1);
    wbValid = 1'b1; wbTag = 4'd8; wbData = 64'h88;
    nextCyc();
    #1;
    chk("R9 head of full buffer", 64'(memWrEn), 64'd1);
    chk("R10 wrap addr", 64'(memWrAddr[0]), 64'h1000);
    nextCyc();
    #1;
    chk("R2 resumes", 64'(allocReady), 64'd1);
    chk("R2 resume tag", 64'(allocTag), 64'd8);
    nextCyc();

    finish();
  end

endmodule